// File: doc/BRIEF.md
# Monitor Region Write Guard and NMI Arbiter

This block sits on a processor bus next to a resident debug monitor. Every bus cycle is decoded against a fixed address window that belongs to the monitor. A user-mode write that lands inside the window loses its write strobe in that same cycle, so the store never reaches memory. The attempt is latched as a violation event instead.

The block also owns the processor's non-maskable interrupt line. Three sources can raise it: the user's own hardware NMI input, a manual break pulse from the console keyboard, and the write violation. Each source sets its own sticky bit in a cause register. The interrupt line is driven only while the processor runs user code. A request that arrives while the monitor is running waits and appears as soon as user mode resumes. Because a break arrives as an interrupt and not as a reset, the processor stacks the user's full register state before it enters the monitor. The monitor reads the cause register to learn why it was entered, and clears it either by reading it or by writing ones to selected bits.

Top module: `mon_guard`

## Requirements
- R1: A cycle with bus_valid=1, bus_wr=1, mon_mode=0 and an address inside the window drives wr_en_q low in that same cycle. Every other write cycle drives wr_en_q high.
- R2: An address counts as inside the window when WIN_BASE <= addr < WIN_LIMIT. The base address is protected and the limit address is not. A limit equal to 2**ADDR_W protects everything up to the top of the address space.
- R3: A blocked write sets cause bit 2 (violation) at the next clock edge.
- R4: A rising edge on usr_nmi sets cause bit 0 at the next clock edge. If usr_nmi stays high after the bit is cleared, the bit does not set again.
- R5: brk_req high for one cycle sets cause bit 1 at the next clock edge.
- R6: nmi_req is high exactly when some cause bit is set and mon_mode is 0. It is never high while mon_mode is 1.
- R7: An event that arrives while mon_mode=1 stays pending. nmi_req rises in the first cycle in which mon_mode is 0.
- R8: Writes made in monitor mode and all read cycles leave wr_en_q unaffected by the window and set no violation bit.
- R9: cause_rd=1 clears every cause bit at the next edge. cause_w1c=1 clears only the bits that are one in w1c_mask.
- R10: An event that sets a bit in the same cycle as a clear of that bit leaves the bit set.
- R11: After reset all cause bits are 0 and nmi_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_valid | input | 1 | Bus cycle is valid this clock |
| mon_mode | input | 1 | 1 = monitor executing, 0 = user program executing |
| usr_nmi | input | 1 | User hardware NMI request (edge sensitive) |
| brk_req | input | 1 | Manual break pulse from the console keyboard |
| cause_rd | input | 1 | Monitor read of the cause register; clears it |
| cause_w1c | input | 1 | Monitor write to the cause register |
| w1c_mask | input | 3 | Bits to clear on cause_w1c |
| wr_en_q | output | 1 | Qualified write enable to memory |
| nmi_req | output | 1 | Gated NMI to the processor |
| cause_q | output | 3 | Sticky causes: bit0 user NMI, bit1 break, bit2 violation |

## Verification
The bench builds the block twice. The first instance keeps the default 16-bit bus with a 14 KiB window from 0x8000 up to (not including) 0xB800. On that instance both edges of the window, and the addresses just outside them, are hit directly. The second instance moves the window to the top of the address space, with its limit set to 0x10000. This brings into reach the case where the exclusive limit cannot be expressed in ADDR_W bits, so the check that address 0xFFFF is still protected catches any truncation of the limit comparison.

// File: rtl/mon_guard_pkg.sv
package mon_guard_pkg;
  localparam int NUM_CAUSE = 3;
  localparam int CAUSE_USR = 0;
  localparam int CAUSE_BRK = 1;
  localparam int CAUSE_VIO = 2;

  // Inclusive base, exclusive limit; operands widened so the limit may equal 2**ADDR_W
  function automatic logic addr_in_window(input logic [32:0] addr,
                                          input logic [32:0] base,
                                          input logic [32:0] limit);
    return (addr >= base) && (addr < limit);
  endfunction
endpackage

// File: rtl/mg_win_chk.sv
module mg_win_chk #(
  parameter int          ADDR_W    = 16,
  parameter int unsigned WIN_BASE  = 32'h8000,
  parameter int unsigned WIN_LIMIT = 32'hB800
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              valid,
  input  logic              mon_mode,
  output logic              in_win,
  output logic              viol,
  output logic              wr_en_q
);
  import mon_guard_pkg::*;
  localparam logic [32:0] BASE_X  = {1'b0, WIN_BASE};
  localparam logic [32:0] LIMIT_X = {1'b0, WIN_LIMIT};

  logic [32:0] addr_x;
  logic        wr_cycle;

  always_comb begin
    addr_x   = 33'(addr);
    in_win   = addr_in_window(addr_x, BASE_X, LIMIT_X);
    wr_cycle = valid && wr;
    viol     = wr_cycle && !mon_mode && in_win;
    wr_en_q  = wr_cycle && !viol;
  end
endmodule

// File: rtl/mg_evt_src.sv
module mg_evt_src #(
  parameter int NUM_CAUSE = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 usr_nmi,
  input  logic                 brk_req,
  input  logic                 viol,
  output logic                 usr_rise,
  output logic [NUM_CAUSE-1:0] set_vec
);
  import mon_guard_pkg::*;
  logic usr_nmi_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) usr_nmi_d <= 1'b0;
    else        usr_nmi_d <= usr_nmi;
  end

  always_comb begin
    usr_rise           = usr_nmi && !usr_nmi_d;
    set_vec            = '0;
    set_vec[CAUSE_USR] = usr_rise;
    set_vec[CAUSE_BRK] = brk_req;
    set_vec[CAUSE_VIO] = viol;
  end
endmodule

// File: rtl/mg_cause_reg.sv
module mg_cause_reg #(
  parameter int NUM_CAUSE = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CAUSE-1:0] set_vec,
  input  logic                 rd_clr,
  input  logic                 w1c,
  input  logic [NUM_CAUSE-1:0] w1c_mask,
  output logic [NUM_CAUSE-1:0] cause_q
);
  for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_bit
    logic clr_i;
    assign clr_i = rd_clr || (w1c && w1c_mask[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cause_q[i] <= 1'b0;
      else if (set_vec[i]) cause_q[i] <= 1'b1;
      else if (clr_i)      cause_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/mg_nmi_gate.sv
module mg_nmi_gate #(
  parameter int NUM_CAUSE = 3
) (
  input  logic [NUM_CAUSE-1:0] pend,
  input  logic                 mon_mode,
  output logic                 nmi
);
  assign nmi = (|pend) && !mon_mode;
endmodule

// File: rtl/mon_guard.sv
module mon_guard #(
  parameter int          ADDR_W    = 16,
  parameter int unsigned WIN_BASE  = 32'h8000,
  parameter int unsigned WIN_LIMIT = 32'hB800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_valid,
  input  logic              mon_mode,
  input  logic              usr_nmi,
  input  logic              brk_req,
  input  logic              cause_rd,
  input  logic              cause_w1c,
  input  logic [2:0]        w1c_mask,
  output logic              wr_en_q,
  output logic              nmi_req,
  output logic [2:0]        cause_q
);
  import mon_guard_pkg::*;

  logic                 in_win;
  logic                 viol;
  logic                 usr_rise;
  logic [NUM_CAUSE-1:0] set_vec;

  mg_win_chk #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LIMIT(WIN_LIMIT)) u_win (
    .addr(bus_addr), .wr(bus_wr), .valid(bus_valid), .mon_mode(mon_mode),
    .in_win(in_win), .viol(viol), .wr_en_q(wr_en_q)
  );

  mg_evt_src #(.NUM_CAUSE(NUM_CAUSE)) u_src (
    .clk(clk), .rst_n(rst_n), .usr_nmi(usr_nmi), .brk_req(brk_req),
    .viol(viol), .usr_rise(usr_rise), .set_vec(set_vec)
  );

  mg_cause_reg #(.NUM_CAUSE(NUM_CAUSE)) u_cause (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .rd_clr(cause_rd),
    .w1c(cause_w1c), .w1c_mask(w1c_mask), .cause_q(cause_q)
  );

  mg_nmi_gate #(.NUM_CAUSE(NUM_CAUSE)) u_gate (
    .pend(cause_q), .mon_mode(mon_mode), .nmi(nmi_req)
  );
endmodule

// File: rtl/mon_guard_chk.sv
module mon_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_valid,
  input logic       mon_mode,
  input logic       brk_req,
  input logic       cause_rd,
  input logic       in_win,
  input logic       viol,
  input logic       usr_rise,
  input logic       wr_en_q,
  input logic       nmi_req,
  input logic [2:0] cause_q
);
  p_block_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_wr && !mon_mode && in_win) |-> !wr_en_q);
  p_viol_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> cause_q[2]);
  p_usr_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    usr_rise |=> cause_q[0]);
  p_brk_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> cause_q[1]);
  p_nmi_user_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mon_mode |-> !nmi_req);
  p_pending_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_mode && (cause_q != 3'b000)) |-> nmi_req);
  p_monitor_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_wr && mon_mode) |-> wr_en_q);
  p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_rd && !viol && !brk_req && !usr_rise) |=> (cause_q == 3'b000));
endmodule

bind mon_guard mon_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_valid(bus_valid),
  .mon_mode(mon_mode), .brk_req(brk_req), .cause_rd(cause_rd),
  .in_win(in_win), .viol(viol), .usr_rise(usr_rise), .wr_en_q(wr_en_q),
  .nmi_req(nmi_req), .cause_q(cause_q)
);

// File: tb/test_mon_guard.sv
module test_mon_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_valid = 1'b0, mon_mode = 1'b1;
  logic        usr_nmi = 1'b0, brk_req = 1'b0, cause_rd = 1'b0, cause_w1c = 1'b0;
  logic [2:0]  w1c_mask = '0;
  logic        wr_en_q, nmi_req, wr_en_top, nmi_top;
  logic [2:0]  cause_q, cause_top;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  mon_guard i_mon_guard (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_valid(bus_valid), .mon_mode(mon_mode), .usr_nmi(usr_nmi),
    .brk_req(brk_req), .cause_rd(cause_rd), .cause_w1c(cause_w1c),
    .w1c_mask(w1c_mask), .wr_en_q(wr_en_q), .nmi_req(nmi_req), .cause_q(cause_q)
  );

  mon_guard #(.ADDR_W(16), .WIN_BASE(32'hF000), .WIN_LIMIT(32'h10000)) i_mon_guard_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_valid(bus_valid), .mon_mode(mon_mode), .usr_nmi(usr_nmi),
    .brk_req(brk_req), .cause_rd(cause_rd), .cause_w1c(cause_w1c),
    .w1c_mask(w1c_mask), .wr_en_q(wr_en_top), .nmi_req(nmi_top), .cause_q(cause_top)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one bus cycle from a negedge; combinational outputs are sampled 1 ns later
  task automatic bus(input logic [15:0] a, input logic w, input logic m);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_valid = 1'b1; mon_mode = m;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_valid = 1'b0; bus_wr = 1'b0; brk_req = 1'b0; cause_rd = 1'b0; cause_w1c = 1'b0;
    #1;
  endtask

  task automatic clear_all();
    @(negedge clk);
    bus_valid = 1'b0; mon_mode = 1'b1; cause_rd = 1'b1;
    @(negedge clk);
    cause_rd = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R11 cause", int'(cause_q), 0);
    chk("R11 nmi", int'(nmi_req), 0);
  endtask

  task automatic t_user_write();
    bus(16'h9000, 1'b1, 1'b0);
    chk("R1 blocked", int'(wr_en_q), 0);
    idle();
    chk("R3 cause", int'(cause_q), 3'b100);
    chk("R6 nmi user", int'(nmi_req), 1);
    @(negedge clk); mon_mode = 1'b1; #1;
    chk("R6 nmi monitor", int'(nmi_req), 0);
    clear_all();
    chk("R9 read clear", int'(cause_q), 0);
    bus(16'h1234, 1'b1, 1'b0);
    chk("R1 outside pass", int'(wr_en_q), 1);
    idle();
    chk("R1 no flag", int'(cause_q), 0);
  endtask

  task automatic t_bounds();
    bus(16'h8000, 1'b1, 1'b0); chk("R2 base", int'(wr_en_q), 0);
    bus(16'hB7FF, 1'b1, 1'b0); chk("R2 limit-1", int'(wr_en_q), 0);
    bus(16'hB800, 1'b1, 1'b0); chk("R2 limit", int'(wr_en_q), 1);
    bus(16'h7FFF, 1'b1, 1'b0); chk("R2 base-1", int'(wr_en_q), 1);
    bus(16'hFFFF, 1'b1, 1'b0); chk("R2 top 0xFFFF", int'(wr_en_top), 0);
    bus(16'hEFFF, 1'b1, 1'b0); chk("R2 top below", int'(wr_en_top), 1);
    bus(16'hF000, 1'b1, 1'b0); chk("R2 top base", int'(wr_en_top), 0);
    clear_all();
  endtask

  task automatic t_pass_cases();
    bus(16'h9000, 1'b0, 1'b0);
    chk("R8 read no strobe", int'(wr_en_q), 0);
    bus(16'hA000, 1'b1, 1'b1);
    chk("R8 monitor write", int'(wr_en_q), 1);
    idle();
    chk("R8 no violation", int'(cause_q), 0);
  endtask

  task automatic t_usr_nmi();
    @(negedge clk); mon_mode = 1'b0; usr_nmi = 1'b1;
    @(negedge clk); #1;
    chk("R4 set", int'(cause_q), 3'b001);
    clear_all();
    @(negedge clk); mon_mode = 1'b0;
    @(negedge clk); #1;
    chk("R4 held level no reset", int'(cause_q), 0);
    chk("R6 nmi idle", int'(nmi_req), 0);
    usr_nmi = 1'b0;
  endtask

  task automatic t_pending();
    @(negedge clk); mon_mode = 1'b1; brk_req = 1'b1;
    @(negedge clk); brk_req = 1'b0; #1;
    chk("R5 set", int'(cause_q), 3'b010);
    chk("R7 held off", int'(nmi_req), 0);
    @(negedge clk); #1;
    chk("R7 still held", int'(nmi_req), 0);
    mon_mode = 1'b0; #1;
    chk("R7 release", int'(nmi_req), 1);
    clear_all();
  endtask

  task automatic t_w1c();
    @(negedge clk); mon_mode = 1'b1; brk_req = 1'b1;
    @(negedge clk); brk_req = 1'b0;
    bus(16'h8800, 1'b1, 1'b0);
    @(negedge clk); bus_valid = 1'b0; mon_mode = 1'b1; #1;
    chk("R9 pre", int'(cause_q), 3'b110);
    cause_w1c = 1'b1; w1c_mask = 3'b010;
    @(negedge clk); cause_w1c = 1'b0; w1c_mask = 3'b000; #1;
    chk("R9 masked clear", int'(cause_q), 3'b100);
  endtask

  task automatic t_set_wins();
    @(negedge clk); cause_rd = 1'b1; brk_req = 1'b1;
    @(negedge clk); cause_rd = 1'b0; brk_req = 1'b0; #1;
    chk("R10 set over clear", int'(cause_q), 3'b010);
    @(negedge clk); cause_w1c = 1'b1; w1c_mask = 3'b010; brk_req = 1'b1;
    @(negedge clk); cause_w1c = 1'b0; brk_req = 1'b0; #1;
    chk("R10 set over w1c", int'(cause_q), 3'b010);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_user_write();
    t_bounds();
    t_pass_cases();
    t_usr_nmi();
    t_pending();
    t_w1c();
    t_set_wins();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule